// File: doc/BRIEF.md
# Masked Component Register File with Decoder Commit

This block is the 32-bit register space of one component on a memory-expansion link. A host reaches it through a simple request bus that carries a byte offset, write data, an access size and four byte strobes. The contents after reset depend on the `COMP` parameter, which names the kind of component: a generic device, a type-3 memory device, a logical device, an upstream port, a downstream port or a root port. That choice sets how many capabilities the primary header announces and which sub-capability headers are present. It also decides whether the memory-decoder registers exist and how wide the writable part of the decoder target list is.

Each register has a fixed write mask. A write changes only the bits that are both writable and inside an enabled byte lane, and every other bit keeps its stored value. Software commits decoder settings by writing the commit bit of a decoder control register. In the same cycle the block stores commit as cleared, the error flag as cleared and the committed flag as set, so the next read already returns the finished handshake. Only naturally aligned 4-byte accesses are serviced. Each read returns its data one cycle after the request.

Top module: `cmp_reg_file`

## Requirements
- R1: Only accesses with `size_i` = 2 (4 bytes) are serviced. The other codes are 0 (1 byte), 1 (2 bytes) and 3 (8 bytes). A read with any other code returns zero. A write with any other code changes no register.
- R2: An access whose offset has bits [1:0] not equal to zero is unaligned. An unaligned read returns zero, and an unaligned write changes no register.
- R3: A serviced write stores `(wdata & m) | (old & ~m)`, where `m` is the register's write mask ANDed with the byte-lane mask. The lanes are little-endian: `be_i[k]` enables bits 8k+7..8k.
- R4: Decoder control sits at offset 0x90 + 0x20·i + 0x10, where i is the decoder number; decoder 0 control is at 0xA0. In that register, bit 9 is commit, bit 10 is committed and bit 11 is error. If a write would store commit = 1, the stored value instead has bit 9 = 0, bit 11 = 0 and bit 10 = 1. The next read shows this value. Committed and error are read-only.
- R5: The primary header at offset 0x00 holds ID 1 in bits [15:0], version 1 in bits [19:16], cache/memory version 1 in bits [23:20] and the capability count in bits [31:24]. The count is 2 for a downstream port or a generic device, 3 for an upstream port, a type-3 device or a logical device, and 5 for a root port.
- R6: Each sub-capability header holds the ID in bits [15:0], the version in bits [19:16] and the byte offset of its registers in bits [31:20].
  - The error-reporting header at 0x04 is 2/2 with pointer 0x040.
  - The link header at 0x08 is 4/2 with pointer 0x060.
  - The decoder header at 0x0C is 5/1 with pointer 0x080, present when the count is at least 3.
  - The extended-security header at 0x10 is 6/1, and the snoop header at 0x14 is 8/1. Both are present when the count is 5. Their pointers are 0x090 + 0x20·NUM_DEC and that value + 0x10.
  - A header that is not present reads zero.
- R7: The error registers have these reset values and write masks:
  - Uncorrectable mask (0x44) and uncorrectable severity (0x48): reset 0x1CFFF, write mask 0x1CFFF.
  - Correctable mask (0x50): reset 0x7F, write mask 0x7F.
  - Uncorrectable status (0x40), correctable status (0x4C) and capability/control (0x54): read zero and are read-only.
- R8: When decoders are present, the decoder capability register at 0x80 holds:
  - bits [3:0]: the encoded decoder count (0 for one decoder);
  - bits [7:4]: target count 1;
  - bit 8 = 1 and bit 9 = 1 (256-byte and 4 KiB interleave supported);
  - bit 10 = 0 (no poison-on-error).
  The global control register at 0x84 resets to 0 and has write mask 0x3.
- R9: Each decoder has seven registers, at offsets relative to its base of 0x90 + 0x20·i. Their write masks are:
  - base low (+0x0) and size low (+0x8): 0xF0000000;
  - base high (+0x4), size high (+0xC) and target list high (+0x18): 0xFFFFFFFF;
  - control (+0x10): 0x13FF;
  - target list low (+0x14): 0xF0000000 for device types and 0xFFFFFFFF for port types.
  All of these registers reset to zero.
- R10: Every offset not covered by a register above reads zero and ignores writes. This includes the link region at 0x60, the gap 0x18 to 0x3F and all decoder offsets of a component without decoders.
- R11: `rvalid_o` is 1 in the cycle after a read request and 0 after any other cycle. `rdata_o` is updated together with it. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| size_i | input | 2 | Access size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| be_i | input | 4 | Byte-lane strobes for writes |
| wdata_i | input | 32 | Write data, little-endian |
| rdata_o | output | 32 | Read data, one cycle after the request |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench builds three instances, all with the default `NUM_DEC` = 1 and `ADDR_W` = 8. The first is a root port, which has all five headers and the fully writable target list. The second is a type-3 device, which has decoders with the narrow target-list mask but no security or snoop header. The third is a downstream port, which has no decoders, so its whole decoder range must stay inert. Driving the same bus into all three lets one write show, side by side, how the type-dependent reset image and write masks diverge. The commit handshake, the strobe merge and the rejected sizes and alignments are checked at the very next read.

// File: rtl/cmp_reg_pkg.sv
`timescale 1ns/1ps
package cmp_reg_pkg;

  typedef enum logic [2:0] {
    CT_DEVICE, CT_TYPE3, CT_LOGICAL, CT_UPSTREAM, CT_DOWNSTREAM, CT_ROOT
  } comp_type_e;

  localparam int unsigned CAP_HDR_OFF  = 32'h00;
  localparam int unsigned RAS_HDR_OFF  = 32'h04;
  localparam int unsigned LINK_HDR_OFF = 32'h08;
  localparam int unsigned HDM_HDR_OFF  = 32'h0C;
  localparam int unsigned EXT_HDR_OFF  = 32'h10;
  localparam int unsigned SNP_HDR_OFF  = 32'h14;

  localparam int unsigned RAS_BASE  = 32'h40;
  localparam int unsigned LINK_BASE = 32'h60;
  localparam int unsigned HDM_BASE  = 32'h80;
  localparam int unsigned DEC_BASE  = HDM_BASE + 32'h10;
  localparam int unsigned DEC_STRIDE = 32'h20;
  localparam int unsigned DEC_CTRL_REL = 32'h10;

  localparam int unsigned CTRL_COMMIT    = 9;
  localparam int unsigned CTRL_COMMITTED = 10;
  localparam int unsigned CTRL_ERR       = 11;

  localparam logic [31:0] UNC_MASK  = 32'h0001_CFFF;
  localparam logic [31:0] COR_MASK  = 32'h0000_007F;
  localparam logic [31:0] CTRL_MASK = 32'h0000_13FF;
  localparam logic [31:0] HI_MASK   = 32'hF000_0000;
  localparam logic [31:0] ALL_MASK  = 32'hFFFF_FFFF;

  function automatic int unsigned cap_count(comp_type_e t);
    case (t)
      CT_DEVICE, CT_DOWNSTREAM:           return 2;
      CT_TYPE3, CT_LOGICAL, CT_UPSTREAM:  return 3;
      default:                            return 5;
    endcase
  endfunction

  function automatic logic is_dev(comp_type_e t);
    return (t == CT_DEVICE) || (t == CT_TYPE3) || (t == CT_LOGICAL);
  endfunction

  function automatic int unsigned ext_base(int unsigned nd);
    return DEC_BASE + nd * DEC_STRIDE;
  endfunction

  function automatic logic [31:0] hdr(int unsigned id, int unsigned ver, int unsigned ptr);
    return {ptr[11:0], ver[3:0], id[15:0]};
  endfunction

  function automatic logic [3:0] dec_cnt_enc(int unsigned nd);
    int unsigned e;
    e = (nd == 1) ? 0 : nd / 2;
    return e[3:0];
  endfunction

  function automatic logic in_dec(int unsigned nd, int unsigned off);
    return (off >= DEC_BASE) && (off < DEC_BASE + nd * DEC_STRIDE);
  endfunction

  function automatic logic [31:0] rst_val(comp_type_e t, int unsigned nd, int unsigned off);
    int unsigned c;
    logic [31:0] v;
    c = cap_count(t);
    v = '0;
    if (off == CAP_HDR_OFF)       v = {c[7:0], 4'd1, 4'd1, 16'd1};
    else if (off == RAS_HDR_OFF)  v = hdr(2, 2, RAS_BASE);
    else if (off == LINK_HDR_OFF) v = hdr(4, 2, LINK_BASE);
    else if (off == HDM_HDR_OFF && c >= 3) v = hdr(5, 1, HDM_BASE);
    else if (off == EXT_HDR_OFF && c >= 5) v = hdr(6, 1, ext_base(nd));
    else if (off == SNP_HDR_OFF && c >= 5) v = hdr(8, 1, ext_base(nd) + 16);
    else if (off == RAS_BASE + 4 || off == RAS_BASE + 8) v = UNC_MASK;
    else if (off == RAS_BASE + 16) v = COR_MASK;
    else if (off == HDM_BASE && c >= 3)
      v = {21'd0, 1'b0, 1'b1, 1'b1, 4'd1, dec_cnt_enc(nd)};
    return v;
  endfunction

  function automatic logic [31:0] wr_mask(comp_type_e t, int unsigned nd, int unsigned off);
    int unsigned c;
    int unsigned rel;
    logic [31:0] m;
    c = cap_count(t);
    m = '0;
    if (off == RAS_BASE + 4 || off == RAS_BASE + 8) m = UNC_MASK;
    else if (off == RAS_BASE + 16) m = COR_MASK;
    else if (c >= 3 && off == HDM_BASE + 4) m = 32'h3;
    else if (c >= 3 && in_dec(nd, off)) begin
      rel = (off - DEC_BASE) % DEC_STRIDE;
      case (rel)
        32'h00, 32'h08:         m = HI_MASK;
        32'h04, 32'h0C, 32'h18: m = ALL_MASK;
        32'h10:                 m = CTRL_MASK;
        32'h14:                 m = is_dev(t) ? HI_MASK : ALL_MASK;
        default:                m = '0;
      endcase
    end
    return m;
  endfunction

  function automatic logic is_ctrl(comp_type_e t, int unsigned nd, int unsigned off);
    return (cap_count(t) >= 3) && in_dec(nd, off) &&
           (((off - DEC_BASE) % DEC_STRIDE) == DEC_CTRL_REL);
  endfunction

endpackage

// File: rtl/cmp_reg_acc.sv
`timescale 1ns/1ps
module cmp_reg_acc #(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [3:0]        be_i,
  output logic              wr_ok_o,
  output logic              rd_ok_o,
  output logic              rd_req_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [31:0]       lane_o
);
  logic serviced;

  // only aligned word accesses reach storage
  assign serviced = (addr_i[1:0] == 2'b00) && (size_i == 2'd2);
  assign wr_ok_o  = req_i && we_i && serviced;
  assign rd_ok_o  = req_i && !we_i && serviced;
  assign rd_req_o = req_i && !we_i;
  assign idx_o    = addr_i[ADDR_W-1:2];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_o[8*k +: 8] = {8{be_i[k]}};
  end
endmodule

// File: rtl/cmp_reg_word.sv
`timescale 1ns/1ps
module cmp_reg_word
  import cmp_reg_pkg::*;
#(
  parameter logic [31:0] RST  = '0,
  parameter logic [31:0] MASK = '0,
  parameter bit          CMT  = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] lane_i,
  output logic [31:0] q_o
);
  logic [31:0] m, merged, nxt;

  assign m      = MASK & lane_i;
  assign merged = (wdata_i & m) | (q_o & ~m);

  if (CMT) begin : g_cmt
    // commit resolves within the write cycle
    always_comb begin
      nxt = merged;
      if (merged[CTRL_COMMIT]) begin
        nxt[CTRL_COMMIT]    = 1'b0;
        nxt[CTRL_ERR]       = 1'b0;
        nxt[CTRL_COMMITTED] = 1'b1;
      end
    end
  end else begin : g_plain
    assign nxt = merged;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (wr_i) q_o <= nxt;
  end
endmodule

// File: rtl/cmp_reg_rdport.sv
`timescale 1ns/1ps
module cmp_reg_rdport #(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned NWORDS = 2 ** IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NWORDS-1:0][31:0] words_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic                   rd_ok_i,
  input  logic                   rd_req_i,
  output logic [31:0]            rdata_o,
  output logic                   rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_req_i;
      if (rd_req_i) rdata_o <= rd_ok_i ? words_i[idx_i] : '0;
    end
  end
endmodule

// File: rtl/cmp_reg_file.sv
`timescale 1ns/1ps
module cmp_reg_file
  import cmp_reg_pkg::*;
#(
  parameter comp_type_e  COMP    = CT_TYPE3,
  parameter int unsigned NUM_DEC = 1,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned NWORDS = 2 ** IDX_W;

  logic              wr_ok, rd_ok, rd_req;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       lane;
  logic [NWORDS-1:0][31:0] words;

  cmp_reg_acc #(.ADDR_W(ADDR_W)) u_acc (
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .size_i  (size_i),
    .be_i    (be_i),
    .wr_ok_o (wr_ok),
    .rd_ok_o (rd_ok),
    .rd_req_o(rd_req),
    .idx_o   (idx),
    .lane_o  (lane)
  );

  for (genvar i = 0; i < NWORDS; i++) begin : g_w
    localparam int unsigned OFF = i * 4;
    logic sel;
    assign sel = wr_ok && (idx == IDX_W'(i));
    cmp_reg_word #(
      .RST (rst_val(COMP, NUM_DEC, OFF)),
      .MASK(wr_mask(COMP, NUM_DEC, OFF)),
      .CMT (is_ctrl(COMP, NUM_DEC, OFF))
    ) u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (sel),
      .wdata_i(wdata_i),
      .lane_i (lane),
      .q_o    (words[i])
    );
  end

  cmp_reg_rdport #(.IDX_W(IDX_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .words_i (words),
    .idx_i   (idx),
    .rd_ok_i (rd_ok),
    .rd_req_i(rd_req),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/cmp_reg_file_chk.sv
`timescale 1ns/1ps
module cmp_reg_file_chk
  import cmp_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic [31:0]       rdata_o,
  input logic              rvalid_o
);
  logic rd;
  assign rd = req_i && !we_i;

  // R11
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  // R11
  no_rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  // R1
  size_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && size_i != 2'd2) |=> (rdata_o == 32'd0));
  // R2
  align_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i[1:0] != 2'b00) |=> (rdata_o == 32'd0));
  // R4
  commit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_W'(DEC_BASE + DEC_CTRL_REL))
      |=> (!rdata_o[CTRL_COMMIT] && !rdata_o[CTRL_ERR]));
  // R7
  status_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (addr_i == ADDR_W'(RAS_BASE) || addr_i == ADDR_W'(RAS_BASE + 12)))
      |=> (rdata_o == 32'd0));
  // R10
  gap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i >= ADDR_W'(32'h18) && addr_i < ADDR_W'(RAS_BASE))
      |=> (rdata_o == 32'd0));
endmodule

bind cmp_reg_file cmp_reg_file_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .size_i  (size_i),
  .rdata_o (rdata_o),
  .rvalid_o(rvalid_o)
);

// File: tb/sim_cmp_reg_file.sv
`timescale 1ns/1ps
module sim_cmp_reg_file;
  import cmp_reg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = 2'd2;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1, rd2;
  logic        rv0, rv1, rv2;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] g0, g1, g2;

  always #2.5 clk = ~clk;

  cmp_reg_file #(.COMP(CT_ROOT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .be_i(be), .wdata_i(wdata), .rdata_o(rd0), .rvalid_o(rv0));
  cmp_reg_file #(.COMP(CT_TYPE3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .be_i(be), .wdata_i(wdata), .rdata_o(rd1), .rvalid_o(rv1));
  cmp_reg_file #(.COMP(CT_DOWNSTREAM)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .be_i(be), .wdata_i(wdata), .rdata_o(rd2), .rvalid_o(rv2));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] b = 4'hF,
                    logic [1:0] s = 2'd2);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b; size = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'hF; size = 2'd2;
  endtask

  task automatic rd(logic [7:0] a, logic [1:0] s = 2'd2);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    @(negedge clk);
    req = 1'b0; size = 2'd2;
    g0 = rd0; g1 = rd1; g2 = rd2;
  endtask

  task automatic rd3(string tag, logic [7:0] a, logic [31:0] e0, logic [31:0] e1,
                     logic [31:0] e2, logic [1:0] s = 2'd2);
    rd(a, s);
    chk({tag, " root"}, g0, e0);
    chk({tag, " type3"}, g1, e1);
    chk({tag, " dsp"}, g2, e2);
  endtask

  task automatic t_reset;
    chk("R11 reset rdata", rd0, 32'd0);
    chk("R11 reset rvalid", {31'd0, rv0}, 32'd0);
  endtask

  task automatic t_headers;
    rd3("R5 primary hdr", 8'h00, 32'h0511_0001, 32'h0311_0001, 32'h0211_0001);
    rd3("R6 ras hdr", 8'h04, 32'h0402_0002, 32'h0402_0002, 32'h0402_0002);
    rd3("R6 link hdr", 8'h08, 32'h0602_0004, 32'h0602_0004, 32'h0602_0004);
    rd3("R6 hdm hdr", 8'h0C, 32'h0801_0005, 32'h0801_0005, 32'h0);
    rd3("R6 ext hdr", 8'h10, 32'h0B01_0006, 32'h0, 32'h0);
    rd3("R6 snoop hdr", 8'h14, 32'h0C01_0008, 32'h0, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd3("R6 hdr read-only", 8'h00, 32'h0511_0001, 32'h0311_0001, 32'h0211_0001);
  endtask

  task automatic t_ras;
    rd3("R7 unc mask rst", 8'h44, 32'h1CFFF, 32'h1CFFF, 32'h1CFFF);
    rd3("R7 unc sev rst", 8'h48, 32'h1CFFF, 32'h1CFFF, 32'h1CFFF);
    rd3("R7 cor mask rst", 8'h50, 32'h7F, 32'h7F, 32'h7F);
    wr(8'h44, 32'h0);
    rd3("R7 unc mask clr", 8'h44, 32'h0, 32'h0, 32'h0);
    wr(8'h44, 32'hFFFF_FFFF);
    rd3("R7 unc mask set", 8'h44, 32'h1CFFF, 32'h1CFFF, 32'h1CFFF);
    wr(8'h50, 32'hFFFF_FF00);
    rd3("R7 cor mask clr", 8'h50, 32'h0, 32'h0, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    rd3("R7 unc status ro", 8'h40, 32'h0, 32'h0, 32'h0);
    rd3("R7 cor status ro", 8'h4C, 32'h0, 32'h0, 32'h0);
    rd3("R7 capctl ro", 8'h54, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_hdm_cap;
    rd3("R8 hdm cap", 8'h80, 32'h310, 32'h310, 32'h0);
    rd3("R8 gctl rst", 8'h84, 32'h0, 32'h0, 32'h0);
    wr(8'h84, 32'hFFFF_FFFF);
    rd3("R8 gctl mask", 8'h84, 32'h3, 32'h3, 32'h0);
    wr(8'h80, 32'h0);
    rd3("R8 hdm cap ro", 8'h80, 32'h310, 32'h310, 32'h0);
  endtask

  task automatic t_dec_masks;
    rd3("R9 base lo rst", 8'h90, 32'h0, 32'h0, 32'h0);
    wr(8'h90, 32'hFFFF_FFFF);
    rd3("R9 base lo", 8'h90, 32'hF000_0000, 32'hF000_0000, 32'h0);
    wr(8'h98, 32'hFFFF_FFFF);
    rd3("R9 size lo", 8'h98, 32'hF000_0000, 32'hF000_0000, 32'h0);
    wr(8'h9C, 32'hFFFF_FFFF);
    rd3("R9 size hi", 8'h9C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    wr(8'hA4, 32'hFFFF_FFFF);
    rd3("R9 tgt lo", 8'hA4, 32'hFFFF_FFFF, 32'hF000_0000, 32'h0);
    wr(8'hA8, 32'hFFFF_FFFF);
    rd3("R9 tgt hi", 8'hA8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    wr(8'hA0, 32'hFFFF_FDFF);
    rd3("R9 ctrl mask", 8'hA0, 32'h11FF, 32'h11FF, 32'h0);
  endtask

  task automatic t_commit;
    wr(8'hA0, 32'hFFFF_FFFF);
    rd3("R4 commit result", 8'hA0, 32'h15FF, 32'h15FF, 32'h0);
    wr(8'hA0, 32'h0);
    rd3("R4 committed kept", 8'hA0, 32'h400, 32'h400, 32'h0);
    wr(8'hA0, 32'h0000_0200, 4'b0001);
    rd3("R4 commit lane off", 8'hA0, 32'h400, 32'h400, 32'h0);
  endtask

  task automatic t_strobe;
    wr(8'h94, 32'h0);
    rd3("R3 base hi clr", 8'h94, 32'h0, 32'h0, 32'h0);
    wr(8'h94, 32'hFFFF_FFFF, 4'b0001);
    rd3("R3 lane0", 8'h94, 32'h0000_00FF, 32'h0000_00FF, 32'h0);
    wr(8'h94, 32'h1234_5678, 4'b1100);
    rd3("R3 lanes 3:2", 8'h94, 32'h1234_00FF, 32'h1234_00FF, 32'h0);
  endtask

  task automatic t_size;
    wr(8'h94, 32'h0, 4'hF, 2'd3);
    wr(8'h94, 32'h0, 4'hF, 2'd0);
    wr(8'h94, 32'h0, 4'hF, 2'd1);
    rd3("R1 bad size write", 8'h94, 32'h1234_00FF, 32'h1234_00FF, 32'h0);
    rd3("R1 8B read", 8'h94, 32'h0, 32'h0, 32'h0, 2'd3);
    rd3("R1 1B read", 8'h00, 32'h0, 32'h0, 32'h0, 2'd0);
  endtask

  task automatic t_align;
    wr(8'h96, 32'h0);
    wr(8'h95, 32'h0);
    rd3("R2 unaligned write", 8'h94, 32'h1234_00FF, 32'h1234_00FF, 32'h0);
    rd3("R2 unaligned read", 8'h95, 32'h0, 32'h0, 32'h0);
    rd3("R2 unaligned hdr read", 8'h02, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_uncovered;
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd3("R10 gap", 8'h20, 32'h0, 32'h0, 32'h0);
    rd3("R10 link region", 8'h60, 32'h0, 32'h0, 32'h0);
    rd3("R10 top word", 8'hFC, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_rvalid;
    rd(8'h00);
    chk("R11 rvalid after read", {29'd0, rv0, rv1, rv2}, 32'h7);
    wr(8'h20, 32'h0);
    chk("R11 rvalid after write", {29'd0, rv0, rv1, rv2}, 32'h0);
    @(negedge clk);
    chk("R11 rvalid idle", {29'd0, rv0, rv1, rv2}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_headers();
    t_ras();
    t_hdm_cap();
    t_dec_masks();
    t_commit();
    t_strobe();
    t_size();
    t_align();
    t_uncovered();
    t_rvalid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule